// File: doc/BRIEF.md
# Shared Translation Interlock Lock

This block arbitrates a single interlock control word among several requesters. Agents that walk translation tables take the lock before they walk. Page-table invalidation is held off as long as any holder remains. The word is a lock bit plus a counter. Exactly one update to the word happens in any cycle, and each update reads, modifies and writes back within that one clock. That makes every update atomic without a retry loop.

A mode input picks how the counter is interpreted.

- **Simple mode:** the counter is a nesting depth for one owner of the lock bit. Only the acquire that takes the depth from zero has to wait. It waits for the word to be free of any outside holder, which the external hold input reports.
- **Shared mode:** the counter is a holder count. Any acquire waits while the external exclusive hold is asserted.

In both modes, the release that empties the counter clears the lock bit and raises a one-cycle wake pulse.

Requests are levels and grants are combinational. A grant is given in the cycle in which the word updates, and the new word is visible after the next rising clock edge. When several requests are eligible, the lowest index wins. Within one requester, a release goes ahead of an acquire.

Top module: `xlat_interlock`

## Requirements
- R1: After reset, `lock_o`, `held_o`, `wake_o` and `underflow_o` are 0 and `holder_cnt_o` is 0. No grant is given while all requests are low.
- R2: In simple mode with a count of 0, an acquire is not granted while `excl_i` is 1. Once `excl_i` is 0 it is granted, and after the clock edge `lock_o` is 1 and the count is 1.
- R3: In simple mode with a count above 0, an acquire is granted whatever the value of `excl_i`. It raises the count by exactly one and leaves the lock bit set.
- R4: In simple mode a granted release lowers a nonzero count by one. Only the release that reaches 0 clears `lock_o` and makes `wake_o` 1 for exactly the following cycle.
- R5: In shared mode, no acquire is granted while `excl_i` is 1, at any count. Otherwise, a granted acquire sets `lock_o` and raises the count by one in the same update.
- R6: In shared mode a granted release lowers the count by one. On reaching 0, `lock_o` clears and `wake_o` pulses for one cycle.
- R7: `held_o` is 1 exactly when `holder_cnt_o` is nonzero, and `lock_o` always equals `held_o`.
- R8: At most one grant (acquire or release) is asserted per cycle. The winner is the lowest-index requester that is eligible. A release is always eligible. An acquire is eligible only when R2, R5 or R10 does not block it. At the same index, the release wins over the acquire.
- R9: A release granted at count 0 changes neither the count nor the lock bit and gives no wake pulse. It sets `underflow_o`, which stays 1 until reset.
- R10: The count saturates at 2^CNT_W-1. At that value no acquire is granted, while releases are still granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shared_mode_i | input | 1 | 0 = simple nested mode, 1 = shared counted mode |
| excl_i | input | 1 | External hold on the word: outside owner (simple) or exclusive bit (shared) |
| acq_req_i | input | N_REQ | Acquire request per requester, level |
| rel_req_i | input | N_REQ | Release request per requester, level |
| acq_gnt_o | output | N_REQ | Acquire grant, the word updates at the next edge |
| rel_gnt_o | output | N_REQ | Release grant, the word updates at the next edge |
| lock_o | output | 1 | Lock bit of the control word |
| held_o | output | 1 | Counter is nonzero |
| holder_cnt_o | output | CNT_W | Nesting depth or holder count |
| wake_o | output | 1 | One-cycle pulse after the counter empties |
| underflow_o | output | 1 | Sticky flag for a release at count 0 |

## Verification
The checks assume that `shared_mode_i` changes only while the counter is zero, because one counter serves both interpretations. The stimulus therefore fixes the mode for each phase and resets between phases. They also assume that requests and `excl_i` are synchronous to the clock. The bench drives them just after the falling edge and samples grants before the rising edge. Grant-only probes lower every request before the rising edge, so that a full sweep of request and exclusive-hold patterns at each count leaves the word untouched.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  typedef enum logic {
    ILK_SIMPLE = 1'b0,
    ILK_SHARED = 1'b1
  } ilk_mode_e;

  typedef struct packed {
    logic acq;
    logic rel;
  } ilk_op_t;
endpackage

// File: rtl/ilk_gate.sv
module ilk_gate
  import ilk_pkg::*;
(
  input  ilk_mode_e mode_i,
  input  logic      excl_i,
  input  logic      cnt_zero_i,
  input  logic      cnt_max_i,
  output logic      acq_ok_o
);
  logic mode_ok;

  always_comb begin
    unique case (mode_i)
      ILK_SHARED: mode_ok = !excl_i;
      default:    mode_ok = !cnt_zero_i || !excl_i; // only the first acquire waits
    endcase
  end

  assign acq_ok_o = mode_ok && !cnt_max_i;
endmodule

// File: rtl/ilk_arb.sv
module ilk_arb
  import ilk_pkg::*;
#(
  parameter int N_REQ = 4
) (
  input  logic [N_REQ-1:0] acq_req_i,
  input  logic [N_REQ-1:0] rel_req_i,
  input  logic             acq_ok_i,
  output logic [N_REQ-1:0] acq_gnt_o,
  output logic [N_REQ-1:0] rel_gnt_o,
  output ilk_op_t          op_o
);
  logic [N_REQ-1:0] elig;
  logic [N_REQ:0]   taken;

  assign taken[0] = 1'b0;

  for (genvar gi = 0; gi < N_REQ; gi++) begin : g_slot
    assign elig[gi]      = rel_req_i[gi] | (acq_req_i[gi] & acq_ok_i);
    assign rel_gnt_o[gi] = !taken[gi] & rel_req_i[gi];
    assign acq_gnt_o[gi] = !taken[gi] & !rel_req_i[gi] & acq_req_i[gi] & acq_ok_i;
    assign taken[gi+1]   = taken[gi] | elig[gi];
  end

  assign op_o.acq = |acq_gnt_o;
  assign op_o.rel = |rel_gnt_o;
endmodule

// File: rtl/ilk_word.sv
module ilk_word
  import ilk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ilk_op_t          op_i,
  output logic             lock_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cnt_zero_o,
  output logic             cnt_max_o,
  output logic             wake_o,
  output logic             underflow_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             lock_q, lock_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wake_q, wake_d;
  logic             uf_q, uf_d;

  // single read-modify-write of the word per cycle
  always_comb begin
    lock_d = lock_q;
    cnt_d  = cnt_q;
    wake_d = 1'b0;
    uf_d   = uf_q;
    if (op_i.rel) begin
      if (cnt_q == '0) begin
        uf_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_ONE;
        if (cnt_q == CNT_ONE) begin
          lock_d = 1'b0;
          wake_d = 1'b1;
        end
      end
    end else if (op_i.acq && cnt_q != CNT_MAX) begin
      cnt_d  = cnt_q + CNT_ONE;
      lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      cnt_q  <= '0;
      wake_q <= 1'b0;
      uf_q   <= 1'b0;
    end else begin
      lock_q <= lock_d;
      cnt_q  <= cnt_d;
      wake_q <= wake_d;
      uf_q   <= uf_d;
    end
  end

  assign lock_o      = lock_q;
  assign cnt_o       = cnt_q;
  assign cnt_zero_o  = (cnt_q == '0);
  assign cnt_max_o   = (cnt_q == CNT_MAX);
  assign wake_o      = wake_q;
  assign underflow_o = uf_q;
endmodule

// File: rtl/xlat_interlock.sv
module xlat_interlock
  import ilk_pkg::*;
#(
  parameter int N_REQ = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shared_mode_i,
  input  logic             excl_i,
  input  logic [N_REQ-1:0] acq_req_i,
  input  logic [N_REQ-1:0] rel_req_i,
  output logic [N_REQ-1:0] acq_gnt_o,
  output logic [N_REQ-1:0] rel_gnt_o,
  output logic             lock_o,
  output logic             held_o,
  output logic [CNT_W-1:0] holder_cnt_o,
  output logic             wake_o,
  output logic             underflow_o
);
  ilk_mode_e mode;
  ilk_op_t   op;
  logic      acq_ok;
  logic      cnt_zero;
  logic      cnt_max;

  assign mode = shared_mode_i ? ILK_SHARED : ILK_SIMPLE;

  ilk_gate u_gate (
    .mode_i     (mode),
    .excl_i     (excl_i),
    .cnt_zero_i (cnt_zero),
    .cnt_max_i  (cnt_max),
    .acq_ok_o   (acq_ok)
  );

  ilk_arb #(.N_REQ(N_REQ)) u_arb (
    .acq_req_i (acq_req_i),
    .rel_req_i (rel_req_i),
    .acq_ok_i  (acq_ok),
    .acq_gnt_o (acq_gnt_o),
    .rel_gnt_o (rel_gnt_o),
    .op_o      (op)
  );

  ilk_word #(.CNT_W(CNT_W)) u_word (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .lock_o      (lock_o),
    .cnt_o       (holder_cnt_o),
    .cnt_zero_o  (cnt_zero),
    .cnt_max_o   (cnt_max),
    .wake_o      (wake_o),
    .underflow_o (underflow_o)
  );

  assign held_o = !cnt_zero;
endmodule

// File: rtl/ilk_lock_chk.sv
module ilk_lock_chk #(
  parameter int N_REQ = 4,
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             shared_mode_i,
  input logic             excl_i,
  input logic [N_REQ-1:0] acq_gnt_o,
  input logic [N_REQ-1:0] rel_gnt_o,
  input logic             lock_o,
  input logic             held_o,
  input logic [CNT_W-1:0] holder_cnt_o,
  input logic             wake_o,
  input logic             underflow_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R8
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acq_gnt_o, rel_gnt_o}));

  // R7
  lock_matches_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o == held_o);

  // R2
  simple_first_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shared_mode_i && !held_o && excl_i) |-> !(|acq_gnt_o));

  // R5
  shared_excl_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shared_mode_i && excl_i) |-> !(|acq_gnt_o));

  // R3
  acq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|acq_gnt_o) |=> (holder_cnt_o == CNT_W'($past(holder_cnt_o) + 1'b1)) && lock_o);

  // R4
  wake_on_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(held_o) |-> wake_o);

  // R6
  wake_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> !held_o ##1 !wake_o);

  // R9
  underflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);

  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (holder_cnt_o == CNT_MAX) |-> !(|acq_gnt_o));
endmodule

bind xlat_interlock ilk_lock_chk #(.N_REQ(N_REQ), .CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .shared_mode_i (shared_mode_i),
  .excl_i        (excl_i),
  .acq_gnt_o     (acq_gnt_o),
  .rel_gnt_o     (rel_gnt_o),
  .lock_o        (lock_o),
  .held_o        (held_o),
  .holder_cnt_o  (holder_cnt_o),
  .wake_o        (wake_o),
  .underflow_o   (underflow_o)
);

// File: tb/xlat_interlock_tb.sv
module xlat_interlock_tb;
  localparam int N     = 3;
  localparam int W     = 3;
  localparam int MAXC  = (1 << W) - 1;
  localparam int CYC   = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         shared_mode_i = 1'b0;
  logic         excl_i = 1'b0;
  logic [N-1:0] acq_req_i = '0;
  logic [N-1:0] rel_req_i = '0;
  logic [N-1:0] acq_gnt_o, rel_gnt_o;
  logic         lock_o, held_o, wake_o, underflow_o;
  logic [W-1:0] holder_cnt_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_cnt;
  bit m_wake, m_err;
  logic [31:0] rng = 32'h1bad_5eed;

  always #(CYC/2) clk = ~clk;

  xlat_interlock #(.N_REQ(N), .CNT_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .shared_mode_i(shared_mode_i), .excl_i(excl_i),
    .acq_req_i(acq_req_i), .rel_req_i(rel_req_i),
    .acq_gnt_o(acq_gnt_o), .rel_gnt_o(rel_gnt_o),
    .lock_o(lock_o), .held_o(held_o), .holder_cnt_o(holder_cnt_o),
    .wake_o(wake_o), .underflow_o(underflow_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t = s;
    t ^= t << 13; t ^= t >> 17; t ^= t << 5;
    return t;
  endfunction

  // expected grants from the bench model: {acq, rel}
  function automatic logic [2*N-1:0] exp_gnt(input logic [N-1:0] a, input logic [N-1:0] r);
    logic [N-1:0] ea = '0, er = '0;
    bit ok, got;
    ok = (m_cnt != MAXC) && (shared_mode_i ? !excl_i : (m_cnt != 0 || !excl_i));
    got = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!got && r[i]) begin er[i] = 1'b1; got = 1'b1; end
      else if (!got && a[i] && ok) begin ea[i] = 1'b1; got = 1'b1; end
    end
    return {ea, er};
  endfunction

  task automatic chk_state(input string req);
    chk(holder_cnt_o == W'(m_cnt), req, holder_cnt_o, m_cnt);
    chk(held_o == (m_cnt != 0) && lock_o == (m_cnt != 0), "R7", {lock_o, held_o}, {2{m_cnt != 0}});
    chk(wake_o == m_wake, req, wake_o, m_wake);
    chk(underflow_o == m_err, "R9", underflow_o, m_err);
  endtask

  // called just after negedge: drive, check grants, clock, check state
  task automatic step(input logic [N-1:0] a, input logic [N-1:0] r, input logic x, input string req);
    logic [2*N-1:0] e;
    acq_req_i = a; rel_req_i = r; excl_i = x;
    #1;
    e = exp_gnt(a, r);
    chk({acq_gnt_o, rel_gnt_o} == e, "R8", {acq_gnt_o, rel_gnt_o}, e);
    m_wake = 1'b0;
    if (|e[N-1:0]) begin
      if (m_cnt == 0) m_err = 1'b1;
      else begin m_cnt--; m_wake = (m_cnt == 0); end
    end else if (|e[2*N-1:N]) m_cnt++;
    @(negedge clk);
    acq_req_i = '0; rel_req_i = '0;
    chk_state(req);
  endtask

  // grant-only probe: requests drop before the rising edge, no update
  task automatic probe(input logic [N-1:0] a, input logic [N-1:0] r, input logic x, input string req);
    logic [2*N-1:0] e;
    acq_req_i = a; rel_req_i = r; excl_i = x;
    #1;
    e = exp_gnt(a, r);
    chk({acq_gnt_o, rel_gnt_o} == e, req, {acq_gnt_o, rel_gnt_o}, e);
    acq_req_i = '0; rel_req_i = '0;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic mode);
    rst_ni = 1'b0; shared_mode_i = mode; excl_i = 1'b0;
    acq_req_i = '0; rel_req_i = '0;
    m_cnt = 0; m_wake = 1'b0; m_err = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1
    chk({acq_gnt_o, rel_gnt_o} == '0, "R1", {acq_gnt_o, rel_gnt_o}, 0);
    chk_state("R1");
  endtask

  initial begin
    #(CYC * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(1'b0);
    @(negedge clk);

    // simple mode: R2 first acquire waits on excl
    step(3'b001, 3'b000, 1'b1, "R2");
    chk(holder_cnt_o == 0, "R2", holder_cnt_o, 0);
    step(3'b001, 3'b000, 1'b0, "R2");
    chk(lock_o == 1'b1, "R2", lock_o, 1);
    // R3 nested acquire ignores excl
    step(3'b010, 3'b000, 1'b1, "R3");
    chk(holder_cnt_o == 2, "R3", holder_cnt_o, 2);
    // R4 only the last release wakes
    step(3'b000, 3'b010, 1'b1, "R4");
    chk(wake_o == 1'b0 && lock_o == 1'b1, "R4", {wake_o, lock_o}, 2'b01);
    step(3'b000, 3'b001, 1'b0, "R4");
    chk(wake_o == 1'b1 && lock_o == 1'b0, "R4", {wake_o, lock_o}, 2'b10);
    step(3'b000, 3'b000, 1'b0, "R4");
    chk(wake_o == 1'b0, "R4", wake_o, 0);
    // R9 release at zero
    step(3'b000, 3'b100, 1'b0, "R9");
    chk(underflow_o && holder_cnt_o == 0 && !wake_o, "R9", {underflow_o, wake_o}, 2'b10);
    step(3'b100, 3'b000, 1'b0, "R9");
    chk(underflow_o == 1'b1, "R9", underflow_o, 1);
    step(3'b000, 3'b100, 1'b0, "R9");

    // shared mode: R5 and R6
    do_reset(1'b1);
    @(negedge clk);
    step(3'b001, 3'b000, 1'b1, "R5");
    chk(holder_cnt_o == 0, "R5", holder_cnt_o, 0);
    step(3'b001, 3'b000, 1'b0, "R5");
    step(3'b010, 3'b000, 1'b1, "R5");
    chk(holder_cnt_o == 1, "R5", holder_cnt_o, 1);
    step(3'b010, 3'b000, 1'b0, "R5");
    step(3'b000, 3'b001, 1'b1, "R6");
    step(3'b000, 3'b010, 1'b1, "R6");
    chk(wake_o && !lock_o, "R6", {wake_o, lock_o}, 2'b10);
    // R8 priority: release ahead of acquire at same index
    step(3'b001, 3'b001, 1'b0, "R8");
    chk(underflow_o == 1'b1, "R8", underflow_o, 1);
    // R10 saturation
    for (int i = 0; i < MAXC; i++) step(3'b111, 3'b000, 1'b0, "R10");
    chk(holder_cnt_o == W'(MAXC), "R10", holder_cnt_o, MAXC);
    step(3'b111, 3'b000, 1'b0, "R10");
    chk(holder_cnt_o == W'(MAXC), "R10", holder_cnt_o, MAXC);
    step(3'b001, 3'b100, 1'b0, "R10");
    chk(holder_cnt_o == W'(MAXC - 1), "R10", holder_cnt_o, MAXC - 1);

    // exhaustive grant sweep at every count, both modes
    for (int md = 0; md < 2; md++) begin
      for (int c = 0; c <= MAXC; c++) begin
        do_reset(md[0]);
        @(negedge clk);
        for (int k = 0; k < c; k++) step(3'b001, 3'b000, 1'b0, md[0] ? "R5" : "R3");
        for (int v = 0; v < 128; v++)
          probe(v[2:0], v[5:3], v[6], md[0] ? "R8_R5_R10" : "R8_R2_R10");
        chk_state("R7");
      end
    end

    // long pseudo-random runs, biased phases
    for (int md = 0; md < 2; md++) begin
      do_reset(md[0]);
      @(negedge clk);
      for (int it = 0; it < 4000; it++) begin
        logic [N-1:0] a, r;
        rng = nxt(rng);
        if ((it / 250) % 2 == 0) begin
          a = rng[2:0] | rng[5:3];
          r = rng[8:6] & rng[11:9] & rng[14:12];
        end else begin
          a = rng[2:0] & rng[5:3];
          r = rng[8:6] | rng[11:9];
        end
        step(a, r, rng[20] & rng[21], md[0] ? "R6" : "R4");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule